// File: doc/BRIEF.md
# Pin-Selected Core Clock Source Multiplexer

This block chooses the clock that drives the processor core from a small fixed table of candidate sources. A 3-bit select bus, wired straight from package pins and never stored in any on-chip register, indexes the table. The table holds an external 24 MHz bypass reference, two constant levels and several power-of-two divisions of a fast PLL clock. The two constant levels let a tester step the core one edge at a time by toggling the select pins between them.

The divided clocks come from a chain of toggle flip-flops in the PLL domain. Each stage is fed only by its own state and the stages below it, so the chain behaves as a free-running binary count of PLL edges. The selected source reaches the core clock output through combinational logic only. Moving the select pins mid-pulse can leave one short or lopsided pulse on the core clock, and this is accepted. One stage of the chain also drives a dedicated pin output. A parameter chooses which stage, so that the pin lands near 48 MHz for the PLL rate in use. The default is divide-by-8, about 36 MHz from a 288 MHz PLL.

Top module: `clk_source_select`

## Requirements
- R1: The select code maps to sources as follows: 0 external reference, 1 constant low, 2 constant high, 3 PLL/2, 4 PLL/4, 5 PLL/8.
- R2: With code 0 the core clock follows the external reference input combinationally, with no PLL edge needed, including while reset is asserted.
- R3: Codes 1 and 2 hold the core clock at 0 and 1. Alternating the select between them gives exactly one rising core clock edge per low-to-high switch.
- R4: The PLL/2 stage inverts itself on every rising PLL edge at which reset is low. The first such edge after reset release sets it to 1.
- R5: The PLL/4 and PLL/8 stages toggle only on a rising PLL edge at which every lower stage is 1. After n rising edges since reset release, the stages read n modulo 8, with PLL/2 as the least significant bit.
- R6: While the active-high reset is sampled high on a rising PLL edge, all divider stages are cleared to 0.
- R7: Reset has no effect on codes 0, 1 and 2.
- R8: The pin output equals the divider stage chosen by a parameter (default: the PLL/8 stage, bit 2 of the count) and does not depend on the select code.
- R9: The core clock output follows a change of select code without waiting for any clock edge.
- R10: The unused codes 6 and 7 drive the core clock to constant 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pll_clk | input | 1 | Fast PLL clock that feeds the divider chain |
| rst | input | 1 | Active-high synchronous reset of the divider chain, PLL domain |
| ref_clk | input | 1 | External 24 MHz bypass reference |
| src_sel | input | 3 | Source select taken straight from device pins |
| core_clk | output | 1 | Selected core clock, combinational |
| pin_clk | output | 1 | Divided clock routed to a dedicated output pin |

## Verification
The clocked assertions sample the select bus on PLL edges, so they take for granted that the select pins are steady around those edges and that reset is held for at least two PLL edges. The stimulus therefore changes the select and reset only on falling PLL edges and holds reset for several cycles. The bypass reference is treated as asynchronous to the PLL clock. Its checks are timed from the reference's own edges rather than the PLL's, and no assertion relates the two clocks.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned NUM_SRC = 1 << SEL_W;
    // first table slot that carries a divided PLL clock
    localparam int unsigned DIV_BASE = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_REF    = 3'd0,
        SRC_LOW    = 3'd1,
        SRC_HIGH   = 3'd2,
        SRC_DIV2   = 3'd3,
        SRC_DIV4   = 3'd4,
        SRC_DIV8   = 3'd5,
        SRC_SPARE6 = 3'd6,
        SRC_SPARE7 = 3'd7
    } clk_src_e;

endpackage

// File: rtl/clksel_div_chain.sv
module clksel_div_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic              pll_clk,
    input  logic              rst,
    output logic [STAGES-1:0] taps
);

    // stage 0: inverts on every PLL edge
    always_ff @(posedge pll_clk) begin
        if (rst) taps[0] <= 1'b0;
        else     taps[0] <= ~taps[0];
    end

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge pll_clk) begin
                if (rst)                 taps[k] <= 1'b0;
                else if (&taps[k-1:0])   taps[k] <= ~taps[k];
            end

            // R5
            stage_carry_chk: assert property (@(posedge pll_clk) disable iff (rst)
                (taps[k] != $past(taps[k])) |-> $fell(taps[k-1]));
        end
    endgenerate

    // R4
    div2_toggle_chk: assert property (@(posedge pll_clk) disable iff (rst)
        !$past(rst) |-> (taps[0] != $past(taps[0])));

    // R6
    div_reset_chk: assert property (@(posedge pll_clk) disable iff (rst)
        $fell(rst) |-> (taps == '0));

endmodule

// File: rtl/clksel_src_table.sv
module clksel_src_table
    import clksel_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic               ref_clk,
    input  logic [STAGES-1:0]  taps,
    output logic [NUM_SRC-1:0] srcs
);

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_entry
            if (i == int'(SRC_REF)) begin : g_ref
                assign srcs[i] = ref_clk;
            end else if (i == int'(SRC_HIGH)) begin : g_hi
                assign srcs[i] = 1'b1;
            end else if (i >= DIV_BASE && i < DIV_BASE + STAGES) begin : g_div
                assign srcs[i] = taps[i-DIV_BASE];
            end else begin : g_lo
                // constant low, including unused codes
                assign srcs[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/clksel_mux.sv
module clksel_mux
    import clksel_pkg::*;
(
    input  logic [NUM_SRC-1:0] srcs,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_out
);

    always_comb begin
        clk_out = srcs[sel];
    end

endmodule

// File: rtl/clk_source_select.sv
module clk_source_select
    import clksel_pkg::*;
#(
    parameter int unsigned DIV_STAGES = 3,
    // log2 of the division routed to the pin (1..DIV_STAGES)
    parameter int unsigned PIN_LOG2   = 3
) (
    input  logic             pll_clk,
    input  logic             rst,
    input  logic             ref_clk,
    input  logic [SEL_W-1:0] src_sel,
    output logic             core_clk,
    output logic             pin_clk
);

    localparam int unsigned PIN_IDX = PIN_LOG2 - 1;

    logic [DIV_STAGES-1:0] taps;
    logic [NUM_SRC-1:0]    srcs;

    clksel_div_chain #(.STAGES(DIV_STAGES)) u_chain (
        .pll_clk (pll_clk),
        .rst     (rst),
        .taps    (taps)
    );

    clksel_src_table #(.STAGES(DIV_STAGES)) u_table (
        .ref_clk (ref_clk),
        .taps    (taps),
        .srcs    (srcs)
    );

    clksel_mux u_mux (
        .srcs    (srcs),
        .sel     (src_sel),
        .clk_out (core_clk)
    );

    assign pin_clk = taps[PIN_IDX];

    // R3
    const_low_chk: assert property (@(posedge pll_clk) disable iff (rst)
        (src_sel == SRC_LOW) |-> !core_clk);

    // R3
    const_high_chk: assert property (@(posedge pll_clk) disable iff (rst)
        (src_sel == SRC_HIGH) |-> core_clk);

    // R10
    spare_low_chk: assert property (@(posedge pll_clk) disable iff (rst)
        (src_sel == SRC_SPARE6 || src_sel == SRC_SPARE7) |-> !core_clk);

    // R8
    pin_sel_free_chk: assert property (@(posedge pll_clk) disable iff (rst)
        (src_sel == SRC_DIV8) |-> (pin_clk == core_clk));

endmodule

// File: tb/sim_clk_source_select.sv
`timescale 1ns/100ps
module sim_clk_source_select;

    logic       pll_clk = 1'b0;
    logic       rst     = 1'b1;
    logic       ref_clk = 1'b0;
    logic [2:0] src_sel = 3'd0;
    logic       core_clk;
    logic       pin_clk;

    int checks = 0;
    int errors = 0;
    logic [2:0] n_edges = 3'd0;   // bench model of PLL edges since reset
    int core_rises = 0;
    bit finished = 0;

    always #4 pll_clk = ~pll_clk;      // 125 MHz
    always #20.5 ref_clk = ~ref_clk;   // asynchronous bypass reference

    always @(posedge pll_clk) begin
        if (rst) n_edges <= 3'd0;
        else     n_edges <= n_edges + 3'd1;
    end

    always @(posedge core_clk) core_rises++;

    clk_source_select u0 (
        .pll_clk  (pll_clk),
        .rst      (rst),
        .ref_clk  (ref_clk),
        .src_sel  (src_sel),
        .core_clk (core_clk),
        .pin_clk  (pin_clk)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        @(negedge pll_clk);
        src_sel = 3'd3;
        #1;
        chk("R6 div2 in reset", core_clk, 1'b0);
        chk("R6 pin in reset", pin_clk, 1'b0);
        src_sel = 3'd5;
        #1;
        chk("R6 div8 in reset", core_clk, 1'b0);
    endtask

    task automatic t_divs;
        // R4 R5 R8: compare each stage to the edge count model
        for (int c = 0; c < 20; c++) begin
            @(negedge pll_clk);
            src_sel = 3'd3; #1; chk("R4 div2", core_clk, n_edges[0]);
            src_sel = 3'd4; #1; chk("R5 div4", core_clk, n_edges[1]);
            src_sel = 3'd5; #1; chk("R5 div8", core_clk, n_edges[2]);
            src_sel = 3'(c % 8); #1;
            chk("R8 pin tap", pin_clk, n_edges[2]);
        end
    endtask

    task automatic t_first_edge;
        // R4: first edge after release sets PLL/2 to 1
        @(negedge pll_clk);
        rst = 1'b1;
        repeat (3) @(negedge pll_clk);
        rst = 1'b0;
        src_sel = 3'd3;
        @(negedge pll_clk);
        chk("R4 first edge", core_clk, 1'b1);
        src_sel = 3'd4; #1;
        chk("R5 div4 after first edge", core_clk, 1'b0);
    endtask

    task automatic t_ref;
        @(negedge pll_clk);
        src_sel = 3'd0;
        for (int c = 0; c < 6; c++) begin
            @(ref_clk); #1;
            chk("R2 bypass", core_clk, ref_clk);
        end
    endtask

    task automatic t_manual;
        int start;
        @(negedge pll_clk);
        src_sel = 3'd1; #1;
        chk("R3 const low", core_clk, 1'b0);
        start = core_rises;
        for (int c = 0; c < 3; c++) begin
            src_sel = 3'd2; #1;
            chk("R9 high immediate", core_clk, 1'b1);
            src_sel = 3'd1; #1;
            chk("R9 low immediate", core_clk, 1'b0);
        end
        checks++;
        if (core_rises - start != 3) begin
            errors++;
            $display("FAIL R3 manual steps: actual %0d expected 3", core_rises - start);
        end
    endtask

    task automatic t_spare;
        for (int c = 0; c < 8; c++) begin
            @(negedge pll_clk);
            src_sel = 3'd6; #1; chk("R10 code6", core_clk, 1'b0);
            src_sel = 3'd7; #1; chk("R10 code7", core_clk, 1'b0);
        end
    endtask

    task automatic t_reset_midrun;
        repeat (5) @(negedge pll_clk);
        rst = 1'b1;
        @(negedge pll_clk);
        src_sel = 3'd3; #1; chk("R6 mid reset div2", core_clk, 1'b0);
        src_sel = 3'd4; #1; chk("R6 mid reset div4", core_clk, 1'b0);
        chk("R6 mid reset pin", pin_clk, 1'b0);
        src_sel = 3'd2; #1; chk("R7 high in reset", core_clk, 1'b1);
        src_sel = 3'd1; #1; chk("R7 low in reset", core_clk, 1'b0);
        src_sel = 3'd0;
        for (int c = 0; c < 4; c++) begin
            @(ref_clk); #1;
            chk("R7 bypass in reset", core_clk, ref_clk);
        end
        @(negedge pll_clk);
        rst = 1'b0;
        // R1: code map after release
        @(negedge pll_clk);
        src_sel = 3'd3; #1; chk("R1 code3 is div2", core_clk, n_edges[0]);
        src_sel = 3'd2; #1; chk("R1 code2 is high", core_clk, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge pll_clk);
        t_reset();
        rst = 1'b0;
        t_divs();
        t_first_edge();
        t_divs();
        t_ref();
        t_manual();
        t_spare();
        t_reset_midrun();
        t_divs();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule